// File: doc/BRIEF.md
# Look-Ahead Route Stage with Time-Redundant Checking

This block is the route stage of a 3D mesh router input port. A header flit arrives with the output port of this router already attached, because the upstream node computed it. The block uses that carried port to work out which neighbour the flit moves to next. It then computes the port that neighbour must use. Routing is dimension-ordered: X is resolved first, then Y, then Z. The local port is chosen once all three coordinates agree.

Transient faults in the route logic are caught by time redundancy, not by copying the logic. A single route engine evaluates each header twice on consecutive cycles, and the two results are compared. If they agree, the first result is released. If they differ, the engine runs a third time in a recovery cycle, and a bitwise 2-of-3 vote picks the result. When the vote does not give exactly one port, a flag pulses and the first result is kept.

Body and tail flits are not recomputed. They reuse the port settled by their header. Every accepted flit also raises a switch request, which carries the port brought in with the header. A stall output holds the upstream buffer read while a check or recovery cycle is in progress.

Top module: `lar_route_guard`

## Requirements
- R1: After reset, `stall`, `out_valid`, `sw_req` and `vote_err` are low.
- R2: Ports are one-hot over 7 bits: bit0 local, bit1 north (+y), bit2 east (+x), bit3 south (-y), bit4 west (-x), bit5 up (+z), bit6 down (-z).
- R3: The result is computed for the neighbour reached by stepping the current coordinates one hop in the direction of `in_port`. A local `in_port` means no step.
- R4: From that neighbour, the route is +x/-x while x differs, else +y/-y while y differs, else +z/-z while z differs, else local.
- R5: A header accepted at edge k (`in_valid`, `in_head`, `stall` low) raises `stall` for one cycle. When the two computations agree, `out_valid` is high for one cycle after edge k+1, with the first result on `out_port`.
- R6: When the second computation differs from the first, `stall` stays high for a second cycle. `out_valid` then rises after edge k+2, and `out_port` is the bitwise majority of the three results.
- R7: When the bitwise majority does not have exactly one bit set, `vote_err` pulses with `out_valid`, and `out_port` is the first result.
- R8: A non-header flit accepted at edge k gives `out_valid` after edge k, with the last settled header port on `out_port`. It causes no stall.
- R9: Every accepted flit gives a one-cycle `sw_req` after its acceptance edge. `sw_port` is the header's carried `in_port`: the flit's own for a header, the latest header's for a body flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Flit offered |
| in_head | input | 1 | Offered flit is a header |
| dst_x | input | CW | Destination x |
| dst_y | input | CW | Destination y |
| dst_z | input | CW | Destination z |
| in_port | input | 7 | Carried output port of this node, one-hot |
| cur_x | input | CW | This node's x |
| cur_y | input | CW | This node's y |
| cur_z | input | CW | This node's z |
| inj_mask | input | 7 | XOR mask on the result computed in the current cycle (test use) |
| stall | output | 1 | Hold the upstream read; no flit accepted |
| out_valid | output | 1 | Result for the downstream node is valid |
| out_port | output | 7 | Port the downstream node will use |
| sw_req | output | 1 | Switch request to the allocator |
| sw_port | output | 7 | Requested output port |
| vote_err | output | 1 | Vote gave no single port |

## Verification
The bench uses the default coordinate width of 3, which gives an 8-per-side mesh. With the node placed at (3,4,2), every carried direction and every route outcome can be reached without wrapping. Fault masks are set at chosen cycles so that a fault lands on the first, the second or only the third computation. Two masks are also combined so that the vote becomes ambiguous. These runs cover both the extra stall cycle and the case where no extra cycle occurs.

// File: rtl/lar_pkg.sv
package lar_pkg;
    localparam int NPORT = 7;
    localparam int NDIM  = 3;

    // one-hot bit positions of the ports
    localparam int B_LOCAL = 0;
    localparam int B_NORTH = 1;
    localparam int B_EAST  = 2;
    localparam int B_SOUTH = 3;
    localparam int B_WEST  = 4;
    localparam int B_UP    = 5;
    localparam int B_DOWN  = 6;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_CHECK   = 2'd1,
        PH_RECOVER = 2'd2
    } phase_e;

    // dimension 0 = x, 1 = y, 2 = z
    function automatic int plus_bit(input int d);
        case (d)
            0:       return B_EAST;
            1:       return B_NORTH;
            default: return B_UP;
        endcase
    endfunction

    function automatic int minus_bit(input int d);
        case (d)
            0:       return B_WEST;
            1:       return B_SOUTH;
            default: return B_DOWN;
        endcase
    endfunction
endpackage

// File: rtl/lar_next_hop.sv
module lar_next_hop
    import lar_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic [NDIM-1:0][CW-1:0] here,
    input  logic [NPORT-1:0]        port,
    output logic [NDIM-1:0][CW-1:0] nbr
);
    for (genvar d = 0; d < NDIM; d++) begin : g_dim
        localparam int PB = plus_bit(d);
        localparam int MB = minus_bit(d);
        always_comb begin
            if (port[PB])
                nbr[d] = here[d] + CW'(1);
            else if (port[MB])
                nbr[d] = here[d] - CW'(1);
            else
                nbr[d] = here[d];
        end
    end
endmodule

// File: rtl/lar_dor.sv
module lar_dor
    import lar_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic [NDIM-1:0][CW-1:0] dst,
    input  logic [NDIM-1:0][CW-1:0] here,
    output logic [NPORT-1:0]        port
);
    logic found;
    always_comb begin
        port  = '0;
        found = 1'b0;
        for (int d = 0; d < NDIM; d++) begin
            if (!found && (dst[d] != here[d])) begin
                if (dst[d] > here[d])
                    port[plus_bit(d)] = 1'b1;
                else
                    port[minus_bit(d)] = 1'b1;
                found = 1'b1;
            end
        end
        if (!found)
            port[B_LOCAL] = 1'b1;
    end
endmodule

// File: rtl/lar_vote.sv
module lar_vote
    import lar_pkg::*;
(
    input  logic [NPORT-1:0] a,
    input  logic [NPORT-1:0] b,
    input  logic [NPORT-1:0] c,
    output logic [NPORT-1:0] maj,
    output logic             single
);
    always_comb begin
        maj    = (a & b) | (a & c) | (b & c);
        single = ($countones(maj) == 1);
    end
endmodule

// File: rtl/lar_route_guard.sv
module lar_route_guard
    import lar_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_head,
    input  logic [CW-1:0]    dst_x,
    input  logic [CW-1:0]    dst_y,
    input  logic [CW-1:0]    dst_z,
    input  logic [NPORT-1:0] in_port,
    input  logic [CW-1:0]    cur_x,
    input  logic [CW-1:0]    cur_y,
    input  logic [CW-1:0]    cur_z,
    input  logic [NPORT-1:0] inj_mask,
    output logic             stall,
    output logic             out_valid,
    output logic [NPORT-1:0] out_port,
    output logic             sw_req,
    output logic [NPORT-1:0] sw_port,
    output logic             vote_err
);
    typedef struct packed {
        phase_e                  phase;
        logic [NDIM-1:0][CW-1:0] dst;
        logic [NPORT-1:0]        carried;
        logic [NPORT-1:0]        r1;
        logic [NPORT-1:0]        r2;
        logic [NPORT-1:0]        route;
        logic                    ov;
        logic [NPORT-1:0]        op;
        logic                    sr;
        logic [NPORT-1:0]        sp;
        logic                    verr;
    } st_t;

    st_t st_d, st_q;

    logic [NDIM-1:0][CW-1:0] here;
    logic [NDIM-1:0][CW-1:0] live_dst;
    logic [NDIM-1:0][CW-1:0] eng_dst;
    logic [NPORT-1:0]        eng_port;
    logic [NDIM-1:0][CW-1:0] eng_nbr;
    logic [NPORT-1:0]        eng_raw;
    logic [NPORT-1:0]        eng_res;
    logic [NPORT-1:0]        maj;
    logic                    maj_single;
    logic                    idle;

    assign here     = {cur_z, cur_y, cur_x};
    assign live_dst = {dst_z, dst_y, dst_x};
    assign idle     = (st_q.phase == PH_IDLE);

    // one shared engine: live operands on the first pass, captured ones after
    assign eng_dst  = idle ? live_dst : st_q.dst;
    assign eng_port = idle ? in_port  : st_q.carried;

    lar_next_hop #(.CW(CW)) u_hop (
        .here (here),
        .port (eng_port),
        .nbr  (eng_nbr)
    );

    lar_dor #(.CW(CW)) u_dor (
        .dst  (eng_dst),
        .here (eng_nbr),
        .port (eng_raw)
    );

    assign eng_res = eng_raw ^ inj_mask;

    lar_vote u_vote (
        .a      (st_q.r1),
        .b      (st_q.r2),
        .c      (eng_res),
        .maj    (maj),
        .single (maj_single)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ov   = 1'b0;
        st_d.sr   = 1'b0;
        st_d.verr = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (in_valid) begin
                    st_d.sr = 1'b1;
                    if (in_head) begin
                        st_d.sp      = in_port;
                        st_d.carried = in_port;
                        st_d.dst     = live_dst;
                        st_d.r1      = eng_res;
                        st_d.phase   = PH_CHECK;
                    end else begin
                        st_d.sp = st_q.carried;
                        st_d.ov = 1'b1;
                        st_d.op = st_q.route;
                    end
                end
            end
            PH_CHECK: begin
                if (eng_res == st_q.r1) begin
                    st_d.ov    = 1'b1;
                    st_d.op    = st_q.r1;
                    st_d.route = st_q.r1;
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.r2    = eng_res;
                    st_d.phase = PH_RECOVER;
                end
            end
            PH_RECOVER: begin
                st_d.ov    = 1'b1;
                st_d.op    = maj_single ? maj : st_q.r1;
                st_d.route = maj_single ? maj : st_q.r1;
                st_d.verr  = !maj_single;
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign stall     = !idle;
    assign out_valid = st_q.ov;
    assign out_port  = st_q.op;
    assign sw_req    = st_q.sr;
    assign sw_port   = st_q.sp;
    assign vote_err  = st_q.verr;
endmodule

// File: rtl/lar_route_guard_chk.sv
module lar_route_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_head,
    input logic stall,
    input logic out_valid,
    input logic sw_req,
    input logic vote_err
);
    // R5: an accepted header always costs at least one check cycle
    a_r5_header_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_head && !stall) |=> stall);

    // R6: at most one recovery cycle follows the check cycle
    a_r6_stall_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && $past(stall)) |=> !stall);

    // R7: a vote error is reported together with a released result
    a_r7_err_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        vote_err |-> out_valid);

    // R8: a body flit passes in one cycle and never stalls
    a_r8_body_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_head && !stall) |=> (out_valid && !stall));

    // R9: each accepted flit raises a switch request
    a_r9_request: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !stall) |=> sw_req);
endmodule

bind lar_route_guard lar_route_guard_chk u_chk (.*);

// File: tb/lar_route_guard_test.sv
`timescale 1ns/1ps
module lar_route_guard_test;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_head;
    logic [CW-1:0] dst_x, dst_y, dst_z, cur_x, cur_y, cur_z;
    logic [6:0]    in_port, inj_mask;
    logic          stall, out_valid, sw_req, vote_err;
    logic [6:0]    out_port, sw_port;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    localparam logic [6:0] LOC = 7'b0000001, NOR = 7'b0000010, EAS = 7'b0000100,
                           SOU = 7'b0001000, WES = 7'b0010000, UPP = 7'b0100000,
                           DWN = 7'b1000000;

    always #4 clk = ~clk;

    lar_route_guard #(.CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_head(in_head),
        .dst_x(dst_x), .dst_y(dst_y), .dst_z(dst_z), .in_port(in_port),
        .cur_x(cur_x), .cur_y(cur_y), .cur_z(cur_z), .inj_mask(inj_mask),
        .stall(stall), .out_valid(out_valid), .out_port(out_port),
        .sw_req(sw_req), .sw_port(sw_port), .vote_err(vote_err)
    );

    task automatic chk(input bit ok, input string req, input logic [6:0] act, input logic [6:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // reference: step one hop along carried port, then X/Y/Z order
    function automatic logic [6:0] model(input int dx, input int dy, input int dz,
                                         input logic [6:0] cp);
        int nx = cur_x, ny = cur_y, nz = cur_z;
        if (cp == EAS) nx++;
        if (cp == WES) nx--;
        if (cp == NOR) ny++;
        if (cp == SOU) ny--;
        if (cp == UPP) nz++;
        if (cp == DWN) nz--;
        if (dx > nx) return EAS;
        if (dx < nx) return WES;
        if (dy > ny) return NOR;
        if (dy < ny) return SOU;
        if (dz > nz) return UPP;
        if (dz < nz) return DWN;
        return LOC;
    endfunction

    logic [6:0] last_carried = '0;
    logic [6:0] last_route   = '0;

    task automatic send_header(input int dx, input int dy, input int dz, input logic [6:0] cp,
                               input logic [6:0] m1, input logic [6:0] m2, input logic [6:0] m3,
                               input string tag);
        logic [6:0] e, r1, r2, r3, mj, fin;
        bit recov, err;
        e  = model(dx, dy, dz, cp);
        r1 = e ^ m1; r2 = e ^ m2; r3 = e ^ m3;
        recov = (r1 != r2);
        mj  = (r1 & r2) | (r1 & r3) | (r2 & r3);
        err = recov && ($countones(mj) != 1);
        fin = !recov ? r1 : (err ? r1 : mj);
        @(negedge clk);
        in_valid = 1; in_head = 1; dst_x = CW'(dx); dst_y = CW'(dy); dst_z = CW'(dz);
        in_port = cp; inj_mask = m1;
        @(posedge clk); @(negedge clk);
        in_valid = 0; inj_mask = m2;
        chk(stall == 1'b1, {"R5 check stall ", tag}, {6'd0, stall}, 7'd1);
        chk(out_valid == 1'b0, {"R5 no early result ", tag}, {6'd0, out_valid}, 7'd0);
        chk(sw_req && sw_port == cp, {"R9 header request ", tag}, sw_port, cp);
        @(posedge clk); @(negedge clk);
        if (recov) begin
            inj_mask = m3;
            chk(stall == 1'b1 && out_valid == 1'b0, {"R6 recovery stall ", tag},
                {5'd0, stall, out_valid}, 7'b10);
            @(posedge clk); @(negedge clk);
        end
        inj_mask = '0;
        chk(out_valid == 1'b1 && stall == 1'b0, {"R5 R6 release ", tag},
            {5'd0, out_valid, stall}, 7'b10);
        chk(out_port == fin, {"R3 R4 R6 port ", tag}, out_port, fin);
        chk(vote_err == err, {"R7 vote flag ", tag}, {6'd0, vote_err}, {6'd0, err});
        last_carried = cp;
        last_route   = fin;
    endtask

    task automatic send_body(input string tag);
        @(negedge clk);
        in_valid = 1; in_head = 0; in_port = 7'b1010101;
        @(posedge clk); @(negedge clk);
        in_valid = 0;
        chk(out_valid && !stall && out_port == last_route, {"R8 body follows ", tag},
            out_port, last_route);
        chk(sw_req && sw_port == last_carried, {"R9 body request ", tag}, sw_port, last_carried);
    endtask

    initial begin
        rst_n = 0; in_valid = 0; in_head = 0; dst_x = 0; dst_y = 0; dst_z = 0;
        in_port = 0; inj_mask = 0; cur_x = 3; cur_y = 4; cur_z = 2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!stall && !out_valid && !sw_req && !vote_err, "R1 reset outputs",
            {3'd0, stall, out_valid, sw_req, vote_err}, 7'd0);
        rst_n = 1;
        // clean headers covering each route outcome (R2 R3 R4 R5)
        send_header(6, 1, 7, EAS, 0, 0, 0, "x plus");
        send_header(4, 1, 7, EAS, 0, 0, 0, "y minus");
        send_header(4, 4, 7, EAS, 0, 0, 0, "z plus");
        send_header(4, 4, 2, EAS, 0, 0, 0, "local after step");
        send_header(0, 7, 0, LOC, 0, 0, 0, "carried local");
        send_header(3, 6, 2, NOR, 0, 0, 0, "north arrive");
        send_header(1, 4, 1, DWN, 0, 0, 0, "west from below");
        send_header(3, 4, 0, UPP, 0, 0, 0, "down from above");
        send_body("after header");
        send_body("second body");
        // faults: first pass, second pass, third pass only, ambiguous vote
        send_header(6, 1, 7, WES, 7'b0000100, 0, 0, "fault first");
        send_body("after recovery");
        send_header(5, 5, 5, SOU, 0, 7'b0100000, 0, "fault second");
        send_header(2, 2, 2, EAS, 0, 0, 7'b0000001, "fault third unused");
        send_header(6, 1, 7, EAS, 7'b0000010, 7'b0001000, 7'b0001010, "ambiguous vote");
        send_body("after vote error");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule